// File: doc/BRIEF.md
# RC Oscillator Trim Calibrator

This block tunes an on-chip RC oscillator against a crystal-derived reference without software in the loop. When asked to calibrate, it walks a signed trim value through a fixed eight-step binary search. For each candidate it drives the oscillator with a seven-digit distributed trim code and runs an external frequency-measurement counter, which counts RC cycles inside a window of fixed length. It then compares the result with a preloaded target of 2048 and moves the candidate up or down, unless the count already lies within a tolerance window.

The measurement counter sits outside the block and is driven through four strobes: an active-low counter reset, a load strobe that presents the target, a start strobe, and a done/count return. The counter's done flag lags the start by a couple of cycles and is still high from the previous run when a new one begins. The sequencer therefore waits for done to fall before it waits for done to rise. When the search ends, the winning code is driven with its enable bit set, a retention hold is raised, and the block reports completion through a one-cycle pulse and a sticky flag.

The controller is a single state machine. Its states are IDLE (waiting for a request), APPLY (drive the candidate code), CRST (counter reset low), LOAD (present target), START (launch measurement), WAIT_LOW (wait for the stale done to clear), WAIT_HIGH (wait for the fresh done and capture the count), EVAL (step the search), COMMIT (drive the final code with enable) and SEAL (raise hold and report done). The transitions are:
- IDLE→APPLY on a start request.
- APPLY→CRST→LOAD→START→WAIT_LOW, unconditionally.
- WAIT_LOW→WAIT_HIGH when done is low.
- WAIT_HIGH→EVAL when done is high.
- EVAL→APPLY while trials remain, and EVAL→COMMIT after the last one.
- COMMIT→SEAL→IDLE, unconditionally.

Top module: `rc_trim_cal`

## Requirements
- R1: After reset, cal_busy, cal_done, cal_done_pulse, trim_en and trim_hold are 0, trim_code is 0, meas_rst_n is 1 and meas_start is 0.
- R2: A cal_start seen while idle makes cal_busy high on the next cycle, and the first candidate value tried is -4 (range top 49 minus half of the 106-value span -56..49).
- R3: The trim code is seven 4-bit digits, digit i at bits 4i+3:4i. With base = floor(value/7) and r = value - 7*base (0..6), digit i holds base+1 for i < r and base otherwise, truncated to 4 bits (two's complement wrap for negatives).
- R4: Every trial pulses meas_rst_n low for one cycle. The next cycle is meas_load with meas_target = 2048, and the cycle after that is meas_start. trim_en and trim_hold are 0 whenever meas_start is high.
- R5: After meas_start, the count is taken only once meas_done has gone low and then high again. trim_code does not change while a measurement is in flight.
- R6: With diff = 2048 - count, a trial with -12 <= diff <= 12 leaves the candidate unchanged. Otherwise the candidate drops by half the step if diff > 0, and rises by half the step if diff < 0 (half rounded down).
- R7: The step starts at 53 and becomes (step+1)>>1 after every trial. Exactly 8 trials run per calibration.
- R8: After the 8th trial, trim_code carries the final candidate's code and trim_en is 1. One cycle later, cal_done_pulse is high for one cycle, and on the following edge cal_done and trim_hold both become 1. cal_done then stays 1 while idle.
- R9: cal_start while cal_busy is high is ignored: the running search keeps its trial sequence and trial count.
- R10: A new calibration clears cal_done, trim_en and trim_hold on the edge that accepts the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Request a calibration (accepted only while idle) |
| cal_busy | output | 1 | Search in progress |
| cal_done_pulse | output | 1 | One-cycle completion pulse |
| cal_done | output | 1 | Sticky completion flag, cleared by the next request |
| trim_code | output | 28 | Seven-digit distributed trim code to the oscillator |
| trim_en | output | 1 | Trim enable, set only with the final code |
| trim_hold | output | 1 | Retention hold for the final code |
| trim_value | output | 8 | Signed candidate value behind trim_code |
| meas_rst_n | output | 1 | Active-low reset of the measurement counter |
| meas_load | output | 1 | Load strobe for the counter target |
| meas_target | output | 13 | Target count presented with the load strobe |
| meas_start | output | 1 | Start strobe for one measurement |
| meas_done | input | 1 | Counter done flag (lags start, stale high at first) |
| meas_count | input | 13 | Counted RC cycles of the last measurement |

## Verification
The bench builds the block with its default parameters: seven 4-bit digits, a 13-bit count, target 2048, tolerance 12, range -56..49 and eight trials. The bench's oscillator model maps the digit sum of the trim code to a count with an adjustable gain and centre. With those values, a single run can reach both ends of the range and the wrapped all-8 digit pattern, and a unit gain puts the diff exactly on ±12 and ±13, the tolerance edges. Varying the counter latency, together with a stale done that stays high for two cycles, shows whether the count is taken too early.

// File: rtl/rctc_pkg.sv
package rctc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_APPLY,
        ST_CRST,
        ST_LOAD,
        ST_START,
        ST_WAIT_LOW,
        ST_WAIT_HIGH,
        ST_EVAL,
        ST_COMMIT,
        ST_SEAL
    } cal_state_e;

endpackage

// File: rtl/rctc_encoder.sv
// Signed candidate value -> distributed multi-digit trim code.
module rctc_encoder #(
    parameter int DIGITS    = 7,
    parameter int DIG_W     = 4,
    parameter int VAL_W     = 8,
    parameter int RANGE_MIN = -56,
    parameter int RANGE_MAX = 49
) (
    input  logic signed [VAL_W-1:0]        value_i,
    output logic        [DIGITS*DIG_W-1:0] code_o
);
    // A bias that is a multiple of DIGITS and of 2**DIG_W makes the
    // dividend non-negative without disturbing the low digit bits.
    localparam int BIAS_Q = 2 << DIG_W;
    localparam int OFFS   = DIGITS * BIAS_Q;
    localparam int U_W    = VAL_W + 2;

    logic [U_W-1:0] biased;
    logic [U_W-1:0] quot;
    logic [U_W-1:0] rem;

    always_comb begin
        biased = U_W'(OFFS) + U_W'(value_i);
        quot   = biased / U_W'(DIGITS);
        rem    = biased % U_W'(DIGITS);
    end

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        assign code_o[d*DIG_W +: DIG_W] = (U_W'(d) < rem) ? DIG_W'(quot + 1'b1)
                                                          : DIG_W'(quot);
    end

    // The signed digits must add back up to the value inside the range.
    always_comb begin
        int sum;
        sum = 0;
        for (int d = 0; d < DIGITS; d++) begin
            sum = sum + int'($signed(code_o[d*DIG_W +: DIG_W]));
        end
        if (!$isunknown(value_i) && int'(value_i) >= RANGE_MIN
            && int'(value_i) <= RANGE_MAX) begin
            assert_digit_sum_R3: assert (sum == int'(value_i))
                else $error("digit sum %0d differs from value %0d", sum, value_i);
        end
    end

endmodule

// File: rtl/rctc_judge.sv
// Compares a measured count with the target and decides the move.
module rctc_judge #(
    parameter int CNT_W    = 13,
    parameter int LOAD_VAL = 2048,
    parameter int TOL      = 12
) (
    input  logic [CNT_W-1:0] count_i,
    output logic             outside_o,
    output logic             go_down_o
);
    localparam int D_W = CNT_W + 1;

    logic signed [D_W-1:0] diff;

    always_comb begin
        diff      = $signed(D_W'(LOAD_VAL)) - $signed({1'b0, count_i});
        outside_o = (diff > $signed(D_W'(TOL))) || (diff < -$signed(D_W'(TOL)));
        go_down_o = diff > $signed(D_W'(0));
    end

endmodule

// File: rtl/rctc_stepper.sv
// Holds the candidate, the step and the trial index of the search.
module rctc_stepper #(
    parameter int VAL_W  = 8,
    parameter int SZ_W   = 6,
    parameter int ITER_W = 4,
    parameter int MID0   = -4,
    parameter int SIZE0  = 53,
    parameter int ITERS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init_i,
    input  logic                    adv_i,
    input  logic                    outside_i,
    input  logic                    go_down_i,
    output logic signed [VAL_W-1:0] mid_o,
    output logic                    last_o
);
    logic signed [VAL_W-1:0] mid_q;
    logic [SZ_W-1:0]         size_q;
    logic [ITER_W-1:0]       iter_q;
    logic signed [VAL_W-1:0] half;

    assign half   = $signed(VAL_W'(size_q >> 1));
    assign mid_o  = mid_q;
    assign last_o = (iter_q == ITER_W'(ITERS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_q  <= VAL_W'(MID0);
            size_q <= SZ_W'(SIZE0);
            iter_q <= '0;
        end else if (init_i) begin
            mid_q  <= VAL_W'(MID0);
            size_q <= SZ_W'(SIZE0);
            iter_q <= '0;
        end else if (adv_i) begin
            if (outside_i) begin
                mid_q <= go_down_i ? (mid_q - half) : (mid_q + half);
            end
            size_q <= SZ_W'(((SZ_W+1)'(size_q) + 1'b1) >> 1);
            iter_q <= iter_q + 1'b1;
        end
    end

    assert_step_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> (size_q <= $past(size_q)))
        else $error("search step grew without a new request");

    assert_iter_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= ITER_W'(ITERS))
        else $error("trial index beyond the trial count");

endmodule

// File: rtl/rc_trim_cal.sv
module rc_trim_cal
    import rctc_pkg::*;
#(
    parameter int DIGITS    = 7,
    parameter int DIG_W     = 4,
    parameter int VAL_W     = 8,
    parameter int CNT_W     = 13,
    parameter int LOAD_VAL  = 2048,
    parameter int TOL       = 12,
    parameter int RANGE_MIN = -56,
    parameter int RANGE_MAX = 49,
    parameter int ITERS     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_start,
    output logic                    cal_busy,
    output logic                    cal_done_pulse,
    output logic                    cal_done,
    output logic [DIGITS*DIG_W-1:0] trim_code,
    output logic                    trim_en,
    output logic                    trim_hold,
    output logic [VAL_W-1:0]        trim_value,
    output logic                    meas_rst_n,
    output logic                    meas_load,
    output logic [CNT_W-1:0]        meas_target,
    output logic                    meas_start,
    input  logic                    meas_done,
    input  logic [CNT_W-1:0]        meas_count
);
    localparam int CODE_W = DIGITS * DIG_W;
    localparam int SPAN   = RANGE_MAX - RANGE_MIN + 1;
    localparam int MID0   = RANGE_MAX - SPAN / 2;
    localparam int SIZE0  = SPAN / 2;
    localparam int SZ_W   = $clog2(SIZE0 + 1);
    localparam int ITER_W = $clog2(ITERS + 1);

    cal_state_e state_q, state_d;

    logic signed [VAL_W-1:0] mid;
    logic                    last_trial;
    logic [CODE_W-1:0]       enc_code;
    logic [CNT_W-1:0]        count_q;
    logic                    outside, go_down;
    logic                    accept;

    logic [CODE_W-1:0]       code_q;
    logic [VAL_W-1:0]        value_q;
    logic                    en_q, hold_q, done_q;

    assign accept = (state_q == ST_IDLE) && cal_start;

    rctc_stepper #(
        .VAL_W (VAL_W),
        .SZ_W  (SZ_W),
        .ITER_W(ITER_W),
        .MID0  (MID0),
        .SIZE0 (SIZE0),
        .ITERS (ITERS)
    ) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (accept),
        .adv_i    (state_q == ST_EVAL),
        .outside_i(outside),
        .go_down_i(go_down),
        .mid_o    (mid),
        .last_o   (last_trial)
    );

    rctc_encoder #(
        .DIGITS   (DIGITS),
        .DIG_W    (DIG_W),
        .VAL_W    (VAL_W),
        .RANGE_MIN(RANGE_MIN),
        .RANGE_MAX(RANGE_MAX)
    ) u_encoder (
        .value_i(mid),
        .code_o (enc_code)
    );

    rctc_judge #(
        .CNT_W   (CNT_W),
        .LOAD_VAL(LOAD_VAL),
        .TOL     (TOL)
    ) u_judge (
        .count_i  (count_q),
        .outside_o(outside),
        .go_down_o(go_down)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (cal_start) state_d = ST_APPLY;
            ST_APPLY:     state_d = ST_CRST;
            ST_CRST:      state_d = ST_LOAD;
            ST_LOAD:      state_d = ST_START;
            ST_START:     state_d = ST_WAIT_LOW;
            ST_WAIT_LOW:  if (!meas_done) state_d = ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (meas_done) state_d = ST_EVAL;
            ST_EVAL:      state_d = last_trial ? ST_COMMIT : ST_APPLY;
            ST_COMMIT:    state_d = ST_SEAL;
            ST_SEAL:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Moore strobes
    always_comb begin
        cal_busy       = (state_q != ST_IDLE);
        meas_rst_n     = (state_q != ST_CRST);
        meas_load      = (state_q == ST_LOAD);
        meas_start     = (state_q == ST_START);
        cal_done_pulse = (state_q == ST_SEAL);
    end

    // Registered datapath outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            value_q <= '0;
            en_q    <= 1'b0;
            hold_q  <= 1'b0;
            done_q  <= 1'b0;
            count_q <= '0;
        end else begin
            if (accept) begin
                en_q   <= 1'b0;
                hold_q <= 1'b0;
                done_q <= 1'b0;
            end
            if (state_q == ST_APPLY || state_q == ST_COMMIT) begin
                code_q  <= enc_code;
                value_q <= mid;
            end
            if (state_q == ST_COMMIT) en_q <= 1'b1;
            if (state_q == ST_WAIT_HIGH && meas_done) count_q <= meas_count;
            if (state_q == ST_SEAL) begin
                hold_q <= 1'b1;
                done_q <= 1'b1;
            end
        end
    end

    assign trim_code   = code_q;
    assign trim_value  = value_q;
    assign trim_en     = en_q;
    assign trim_hold   = hold_q;
    assign cal_done    = done_q;
    assign meas_target = CNT_W'(LOAD_VAL);

    assert_trial_unlocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> (!trim_en && !trim_hold))
        else $error("measurement launched with enable or hold set");

    assert_load_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_load |-> $past(!meas_rst_n))
        else $error("load without a preceding counter reset");

    assert_start_after_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> $past(meas_load))
        else $error("start without a preceding load");

    assert_code_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LOW || state_q == ST_WAIT_HIGH) |-> $stable(trim_code))
        else $error("trim code moved during a measurement");

    assert_seal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done_pulse |=> (cal_done && trim_hold && trim_en && !cal_done_pulse))
        else $error("completion not sealed after the done pulse");

endmodule

// File: tb/tb_rc_trim_cal.sv
`timescale 1ns/1ps
module tb_rc_trim_cal;
    localparam int DIG_W  = 4;
    localparam int DIGITS = 7;
    localparam int CODE_W = 28;
    localparam int VAL_W  = 8;
    localparam int CNT_W  = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cal_start = 1'b0;
    logic cal_busy, cal_done_pulse, cal_done, trim_en, trim_hold;
    logic [CODE_W-1:0] trim_code;
    logic [VAL_W-1:0]  trim_value;
    logic meas_rst_n, meas_load, meas_start;
    logic [CNT_W-1:0] meas_target;
    logic meas_done = 1'b1;
    logic [CNT_W-1:0] meas_count = '0;

    always #2.5 clk = ~clk;

    rc_trim_cal dut (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start),
        .cal_busy(cal_busy), .cal_done_pulse(cal_done_pulse), .cal_done(cal_done),
        .trim_code(trim_code), .trim_en(trim_en), .trim_hold(trim_hold),
        .trim_value(trim_value), .meas_rst_n(meas_rst_n), .meas_load(meas_load),
        .meas_target(meas_target), .meas_start(meas_start),
        .meas_done(meas_done), .meas_count(meas_count)
    );

    int checks = 0;
    int errors = 0;
    int tgt_v, gain, lat_cycles;
    int exp_q[$];
    int exp_final;
    int trials, pulses, phase, stale, lat;
    bit rst_seen, load_seen, prev_done, finished;
    logic [CODE_W-1:0] held_code;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int floor7(int v);
        return (v >= 0) ? v / 7 : -((-v + 6) / 7);
    endfunction

    function automatic logic [CODE_W-1:0] enc(int v);
        logic [CODE_W-1:0] c;
        int base, r, nib;
        base = floor7(v);
        r = v - 7 * base;
        c = '0;
        for (int d = 0; d < DIGITS; d++) begin
            nib = (d < r) ? base + 1 : base;
            c[d*DIG_W +: DIG_W] = 4'(nib);
        end
        return c;
    endfunction

    function automatic int code_val(logic [CODE_W-1:0] c);
        int s;
        s = 0;
        for (int d = 0; d < DIGITS; d++) s += int'($signed(c[d*DIG_W +: DIG_W]));
        return s;
    endfunction

    // Oscillator model: higher trim value -> slower clock -> fewer counts.
    function automatic int osc(logic [CODE_W-1:0] c);
        int n;
        n = 2048 - gain * (code_val(c) - tgt_v);
        if (n < 0) n = 0;
        if (n > 8191) n = 8191;
        return n;
    endfunction

    task automatic build_ref();
        int mid, size, diff;
        mid = -4;
        size = 53;
        exp_q.delete();
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(mid);
            diff = 2048 - osc(enc(mid));
            if (diff > 12 || diff < -12) mid = (diff > 0) ? mid - size / 2 : mid + size / 2;
            size = (size + 1) >> 1;
        end
        exp_final = mid;
    endtask

    // Counter model and per-clock comparison, away from the active edge.
    initial begin
        int e;
        phase = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                phase = 0;
                prev_done = 0;
            end else begin
                if (phase != 0)
                    chk(trim_code == held_code, "R5", "code stable in flight",
                        trim_code, held_code);
                if (!meas_rst_n) begin
                    rst_seen = 1;
                    meas_count = '0;
                end
                if (meas_load) begin
                    chk(rst_seen, "R4", "counter reset before load", rst_seen, 1);
                    chk(meas_target == 13'd2048, "R4", "target", meas_target, 2048);
                    load_seen = 1;
                end
                if (meas_start) begin
                    trials++;
                    chk(load_seen, "R4", "load before start", load_seen, 1);
                    chk(!trim_en && !trim_hold, "R4", "enable/hold low in trial",
                        {trim_en, trim_hold}, 0);
                    if (exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        chk(int'($signed(trim_value)) == e, "R6", "trial value",
                            int'($signed(trim_value)), e);
                        chk(trim_code == enc(e), "R3", "trial code", trim_code, enc(e));
                    end else begin
                        chk(0, "R7", "extra trial", trials, 8);
                    end
                    rst_seen = 0;
                    load_seen = 0;
                    held_code = trim_code;
                    stale = 2;
                    phase = 1;
                end else if (phase == 1) begin
                    stale--;
                    if (stale == 0) begin
                        meas_done = 1'b0;
                        lat = lat_cycles;
                        phase = 2;
                    end
                end else if (phase == 2) begin
                    lat--;
                    if (lat == 0) begin
                        meas_done = 1'b1;
                        meas_count = CNT_W'(osc(held_code));
                        phase = 0;
                    end
                end
                if (cal_done_pulse) pulses++;
                if (cal_done && !prev_done) begin
                    chk(trials == 8, "R7", "trial count", trials, 8);
                    chk(exp_q.size() == 0, "R7", "trials left over", exp_q.size(), 0);
                    chk(int'($signed(trim_value)) == exp_final, "R6", "final value",
                        int'($signed(trim_value)), exp_final);
                    chk(trim_code == enc(exp_final), "R8", "final code",
                        trim_code, enc(exp_final));
                    chk(trim_en && trim_hold, "R8", "enable and hold",
                        {trim_en, trim_hold}, 3);
                    chk(pulses == 1, "R8", "done pulses", pulses, 1);
                    finished = 1;
                end
                prev_done = cal_done;
            end
        end
    end

    task automatic run_cal(input int tv, input int k, input int lt, input bit poke);
        int n;
        tgt_v = tv;
        gain = k;
        lat_cycles = lt;
        build_ref();
        trials = 0;
        pulses = 0;
        finished = 0;
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk(cal_busy, "R2", "busy after request", cal_busy, 1);
        chk(!cal_done && !trim_en && !trim_hold, "R10", "status cleared",
            {cal_done, trim_en, trim_hold}, 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(cal_busy, "R9", "busy before extra request", cal_busy, 1);
            cal_start = 1'b1;
            @(negedge clk);
            cal_start = 1'b0;
        end
        n = 0;
        while (!finished && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(finished, "R8", "calibration completed", finished, 1);
        repeat (3) @(negedge clk);
        chk(!cal_busy && cal_done, "R8", "sticky done while idle",
            {cal_busy, cal_done}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tgt_v = 0;
        gain = 1;
        lat_cycles = 3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cal_busy && !cal_done && !cal_done_pulse, "R1", "idle flags",
            {cal_busy, cal_done, cal_done_pulse}, 0);
        chk(!trim_en && !trim_hold && trim_code == '0, "R1", "trim outputs",
            trim_code, 0);
        chk(meas_rst_n && !meas_start && !meas_load, "R1", "counter strobes",
            {meas_rst_n, meas_start, meas_load}, 4);

        run_cal(17, 10, 4, 1);   // R9: extra request mid-run
        run_cal(-50, 10, 3, 0);
        run_cal(-4, 3, 5, 0);    // converged on the first trial
        run_cal(49, 10, 2, 0);   // top of range
        run_cal(-56, 10, 6, 0);  // bottom of range, wrapped digits
        run_cal(8, 1, 3, 0);     // diff -12: inside window
        run_cal(9, 1, 3, 1);     // diff -13: outside window
        run_cal(-16, 1, 1, 0);   // diff +12: inside window
        run_cal(-17, 1, 4, 0);   // diff +13: outside window

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule